// File: doc/BRIEF.md
# Time-Slotted Coalesced Write Controller

This block merges single 32-bit words from several independent worker ports into one ordered, contiguous write burst toward memory. A head port issues a coalesce command with a base address and an element count. Accepting it opens a slot schedule on a shared time-division channel. The schedule visits slots 0 through count-1 in order, one slot per clock, unless memory backpressure holds it.

Each worker presents a data word tagged with a slot index. The port stays stalled until the schedule reaches that slot, and the word is taken in that slot. Words are not granted by arbitration: the programmed slot index decides where each word lands in the burst. If no worker supplies a slot, the beat is still written, but with its byte lanes disabled, and a sticky flag records that data was missing. A new command waits until the previous burst has fully drained to memory. The head is told when a burst is done.

Top module: `coalesce_wr_ctrl`

## Requirements
- R1: After reset, busy, done, missing and mem_valid are 0 and cmd_ready is 1. A worker word that is present while no burst runs is not accepted.
- R2: A command is accepted in a cycle where cmd_valid and cmd_ready are both high and cmd_size is non-zero. A command with cmd_size of 0 is ignored: busy stays low and no beat is produced.
- R3: An accepted burst of size S produces exactly S memory beats, carrying slots 0 to S-1 in increasing order. The first beat carries mem_addr equal to the command base, and only beat S-1 has mem_last set.
- R4: A worker whose slot index is k is accepted (wr_accept pulses for one cycle) in the cycle slot k is loaded. Its word is then carried on beat k with mem_be equal to 4'hF.
- R5: A worker whose slot index is greater than or equal to the current burst size is not accepted during that burst. It stays stalled and is accepted in a later burst whose size covers the index.
- R6: A slot with no worker word produces a beat with mem_data 0 and mem_be 0. It sets missing, which stays set until the next command is accepted.
- R7: While mem_valid is high and mem_ready is low, the beat is held unchanged, the slot schedule does not advance and no worker is accepted.
- R8: busy is high from the cycle after command acceptance until the final beat is taken by memory. In the following cycle done is high for exactly one cycle and busy is low.
- R9: If several workers present the same slot index, the lowest-numbered port is accepted. The others remain stalled.
- R10: cmd_ready is low while busy, so a second command waits until the previous burst completes. A worker may reuse the same slot index in the next burst, whose address comes only from the new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Head command request |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_base | input | ADDR_W | Burst base address |
| cmd_size | input | SIZE_W | Number of elements in the burst |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle burst completion pulse |
| missing | output | 1 | Sticky flag: a slot of this burst was empty |
| wr_valid | input | N_PORTS | Per-worker word present |
| wr_slot | input | N_PORTS*SLOT_W | Per-worker slot index, packed |
| wr_data | input | N_PORTS*32 | Per-worker data word, packed |
| wr_accept | output | N_PORTS | Per-worker word taken this cycle |
| mem_valid | output | 1 | Beat valid |
| mem_ready | input | 1 | Memory takes beat |
| mem_addr | output | ADDR_W | Burst base address, meaningful on first beat |
| mem_data | output | 32 | Beat data |
| mem_be | output | 4 | Byte lane enables |
| mem_last | output | 1 | Final beat of burst |

## Verification
On every cycle the assertions check several rules. A held beat stays stable under backpressure. At most one worker is accepted, and only one that is presenting a word. The slot counter stays below the size. done is a single-cycle pulse with busy low, and a disabled beat implies the missing flag. Only the bench scenarios can show the ordering of a whole burst against its base address and that an out-of-range index waits for a larger later burst. The same holds for port priority on a shared index, the queuing of a second command, and a size-zero command doing nothing.

// File: rtl/coalesce_pkg.sv
package coalesce_pkg;
  parameter int unsigned WORD_W = 32;
  localparam int unsigned LANES = WORD_W / 8;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lanes_t;
endpackage

// File: rtl/cwc_sequencer.sv
module cwc_sequencer #(
  parameter int ADDR_W = 32,
  parameter int SLOT_W = 4,
  parameter int SIZE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic              advance,
  input  logic              last_taken,
  output logic              cmd_ready,
  output logic              start,
  output logic              busy,
  output logic              issuing,
  output logic              done,
  output logic [SLOT_W-1:0] slot,
  output logic              slot_is_last,
  output logic [SIZE_W-1:0] size_q,
  output logic [ADDR_W-1:0] base_q
);
  logic all_issued;

  assign cmd_ready    = !busy;
  assign start        = cmd_valid && !busy && (cmd_size != '0);
  assign issuing      = busy && !all_issued;
  assign slot_is_last = (SIZE_W'(slot) == size_q - SIZE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      all_issued <= 1'b0;
      done       <= 1'b0;
      slot       <= '0;
      size_q     <= '0;
      base_q     <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy       <= 1'b1;
        all_issued <= 1'b0;
        slot       <= '0;
        size_q     <= cmd_size;
        base_q     <= cmd_base;
      end else begin
        if (advance) begin
          if (slot_is_last) all_issued <= 1'b1;
          else              slot       <= slot + SLOT_W'(1);
        end
        if (last_taken) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_idle_r8:  assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  p_slot_range_r3: assert property (@(posedge clk) disable iff (rst)
                     busy |-> (SIZE_W'(slot) < size_q));
endmodule

// File: rtl/cwc_port_pick.sv
module cwc_port_pick
  import coalesce_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int SLOT_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      enable,
  input  logic [SLOT_W-1:0]         cur_slot,
  input  logic [N_PORTS-1:0]        wr_valid,
  input  logic [N_PORTS*SLOT_W-1:0] wr_slot,
  input  logic [N_PORTS*WORD_W-1:0] wr_data,
  output logic [N_PORTS-1:0]        accept,
  output logic                      hit,
  output word_t                     word
);
  logic [N_PORTS-1:0] match;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_match
    assign match[g] = wr_valid[g] && (wr_slot[g*SLOT_W +: SLOT_W] == cur_slot);
  end

  always_comb begin
    accept = '0;
    hit    = 1'b0;
    word   = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (enable && match[i] && !hit) begin
        hit       = 1'b1;
        accept[i] = 1'b1;
        word      = wr_data[i*WORD_W +: WORD_W];
      end
    end
  end

  p_accept_onehot_r9: assert property (@(posedge clk) disable iff (rst) $onehot0(accept));
  p_accept_valid_r4:  assert property (@(posedge clk) disable iff (rst)
                        (accept & ~wr_valid) == '0);
endmodule

// File: rtl/cwc_beat_reg.sv
module cwc_beat_reg
  import coalesce_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              load,
  input  logic              hit,
  input  word_t             word,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              last_in,
  input  logic              mem_ready,
  output logic              can_load,
  output logic              last_taken,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output word_t             mem_data,
  output lanes_t            mem_be,
  output logic              mem_last,
  output logic              missing
);
  assign can_load   = !mem_valid || mem_ready;
  assign last_taken = mem_valid && mem_ready && mem_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      mem_be    <= '0;
      mem_last  <= 1'b0;
      missing   <= 1'b0;
    end else begin
      if (start) missing <= 1'b0;
      if (load) begin
        mem_valid <= 1'b1;
        mem_addr  <= addr_in;
        mem_data  <= hit ? word : '0;
        mem_be    <= hit ? '1 : '0;
        mem_last  <= last_in;
        if (!hit) missing <= 1'b1;
      end else if (mem_ready) begin
        mem_valid <= 1'b0;
        mem_last  <= 1'b0;
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
               (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data)
                 && $stable(mem_be) && $stable(mem_last)));
  p_empty_flag_r6: assert property (@(posedge clk) disable iff (rst)
               (mem_valid && mem_be == '0) |-> missing);
endmodule

// File: rtl/coalesce_wr_ctrl.sv
module coalesce_wr_ctrl
  import coalesce_pkg::*;
#(
  parameter int N_PORTS   = 4,
  parameter int ADDR_W    = 32,
  parameter int MAX_ELEMS = 16,
  localparam int SLOT_W   = $clog2(MAX_ELEMS),
  localparam int SIZE_W   = $clog2(MAX_ELEMS + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [ADDR_W-1:0]         cmd_base,
  input  logic [SIZE_W-1:0]         cmd_size,
  output logic                      busy,
  output logic                      done,
  output logic                      missing,
  input  logic [N_PORTS-1:0]        wr_valid,
  input  logic [N_PORTS*SLOT_W-1:0] wr_slot,
  input  logic [N_PORTS*WORD_W-1:0] wr_data,
  output logic [N_PORTS-1:0]        wr_accept,
  output logic                      mem_valid,
  input  logic                      mem_ready,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [WORD_W-1:0]         mem_data,
  output logic [LANES-1:0]          mem_be,
  output logic                      mem_last
);
  logic              start, issuing, load, can_load, last_taken, slot_is_last, hit;
  logic [SLOT_W-1:0] slot;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] base_q;
  word_t             word;

  assign load = issuing && can_load;

  cwc_sequencer #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .SIZE_W(SIZE_W)) seq_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_base(cmd_base),
    .cmd_size(cmd_size), .advance(load), .last_taken(last_taken),
    .cmd_ready(cmd_ready), .start(start), .busy(busy), .issuing(issuing),
    .done(done), .slot(slot), .slot_is_last(slot_is_last), .size_q(size_q),
    .base_q(base_q));

  cwc_port_pick #(.N_PORTS(N_PORTS), .SLOT_W(SLOT_W)) pick_i (
    .clk(clk), .rst(rst), .enable(load), .cur_slot(slot), .wr_valid(wr_valid),
    .wr_slot(wr_slot), .wr_data(wr_data), .accept(wr_accept), .hit(hit),
    .word(word));

  cwc_beat_reg #(.ADDR_W(ADDR_W)) beat_i (
    .clk(clk), .rst(rst), .start(start), .load(load), .hit(hit), .word(word),
    .addr_in(base_q), .last_in(slot_is_last), .mem_ready(mem_ready),
    .can_load(can_load), .last_taken(last_taken), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .mem_last(mem_last), .missing(missing));

  p_idle_no_accept_r1: assert property (@(posedge clk) disable iff (rst)
                         !busy |-> (wr_accept == '0));
  p_stall_no_accept_r7: assert property (@(posedge clk) disable iff (rst)
                         (mem_valid && !mem_ready) |-> (wr_accept == '0));
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (rst)
                         busy |-> !cmd_ready);
endmodule

// File: tb/coalesce_wr_ctrl_tb_top.sv
module coalesce_wr_ctrl_tb_top;
  localparam int NP = 4;
  localparam int AW = 32;
  localparam int SW = 4;
  localparam int ZW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [AW-1:0] cmd_base = '0;
  logic [ZW-1:0] cmd_size = '0;
  logic cmd_ready, busy, done, missing;
  logic [NP-1:0] wv = '0;
  logic [NP*SW-1:0] ws = '0;
  logic [NP*32-1:0] wd = '0;
  logic [NP-1:0] wr_accept;
  logic mem_valid, mem_last;
  logic mem_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0] mem_be;

  int total = 0;
  int bad = 0;
  int beat_n = 0;
  int done_n = 0;
  int cyc = 0;
  logic bp_mode = 1'b0;
  logic [31:0] b_data [32];
  logic [AW-1:0] b_addr [32];
  logic [3:0] b_be [32];
  logic b_last [32];

  coalesce_wr_ctrl dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_size(cmd_size), .busy(busy), .done(done),
    .missing(missing), .wr_valid(wv), .wr_slot(ws), .wr_data(wd),
    .wr_accept(wr_accept), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .mem_last(mem_last));

  always #2ns clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (mem_valid && mem_ready && beat_n < 32) begin
        b_data[beat_n] <= mem_data;
        b_addr[beat_n] <= mem_addr;
        b_be[beat_n]   <= mem_be;
        b_last[beat_n] <= mem_last;
        beat_n <= beat_n + 1;
      end
      if (done) done_n <= done_n + 1;
      for (int i = 0; i < NP; i++) if (wr_accept[i]) wv[i] <= 1'b0;
    end
  end

  always @(negedge clk) if (bp_mode) mem_ready = (cyc % 3) != 0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_word(input int p, input int s, input logic [31:0] d);
    @(negedge clk);
    ws[p*SW +: SW] = SW'(s);
    wd[p*32 +: 32] = d;
    wv[p] = 1'b1;
  endtask

  task automatic issue(input logic [AW-1:0] base, input int size);
    @(negedge clk);
    cmd_base = base;
    cmd_size = ZW'(size);
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done_n(input int n);
    int guard = 0;
    while (done_n < n && guard < 500) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic fresh();
    @(negedge clk);
    beat_n = 0;
    done_n = 0;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !missing && !mem_valid && cmd_ready, "R1 reset state",
        {busy, done, missing, mem_valid, cmd_ready}, 5'b00001);
  endtask

  task automatic t_full_burst();
    fresh();
    put_word(0, 3, 32'hA3); put_word(1, 2, 32'hA2);
    put_word(2, 1, 32'hA1); put_word(3, 0, 32'hA0);
    repeat (3) @(negedge clk);
    chk(wv == 4'hF, "R1 no accept while idle", 64'(wv), 64'hF);
    issue(32'h1000, 4);
    chk(busy, "R8 busy after accept", 64'(busy), 1);
    wait_done_n(1);
    chk(!busy, "R8 idle at done", 64'(busy), 0);
    @(negedge clk);
    chk(!done, "R8 done one cycle", 64'(done), 0);
    chk(beat_n == 4, "R3 beat count", 64'(beat_n), 4);
    chk(b_addr[0] == 32'h1000, "R3 first addr", 64'(b_addr[0]), 64'h1000);
    for (int k = 0; k < 4; k++) begin
      chk(b_data[k] == 32'(32'hA0 + k) && b_be[k] == 4'hF, "R4 slot word",
          64'(b_data[k]), 64'(32'hA0 + k));
      chk(b_last[k] == (k == 3), "R3 last flag", 64'(b_last[k]), 64'(k == 3));
    end
    chk(!missing, "R6 no missing", 64'(missing), 0);
  endtask

  task automatic t_gap_and_range();
    fresh();
    put_word(0, 0, 32'hB0); put_word(2, 2, 32'hB2); put_word(1, 5, 32'hB5);
    issue(32'h2000, 3);
    wait_done_n(1);
    @(negedge clk);
    chk(beat_n == 3, "R3 beat count gap", 64'(beat_n), 3);
    chk(b_be[1] == 4'h0 && b_data[1] == 0, "R6 empty beat", 64'(b_be[1]), 0);
    chk(b_data[2] == 32'hB2, "R4 slot2 word", 64'(b_data[2]), 64'hB2);
    chk(missing, "R6 missing set", 64'(missing), 1);
    chk(wv[1], "R5 out of range stalled", 64'(wv[1]), 1);
    fresh();
    issue(32'h3000, 8);
    chk(!missing, "R6 missing cleared by command", 64'(missing), 0);
    wait_done_n(1);
    @(negedge clk);
    chk(!wv[1] && b_data[5] == 32'hB5 && b_be[5] == 4'hF, "R5 later burst takes index",
        64'(b_data[5]), 64'hB5);
    chk(missing, "R6 sticky after burst", 64'(missing), 1);
  endtask

  task automatic t_backpressure();
    fresh();
    for (int p = 0; p < 4; p++) put_word(p, p, 32'(32'hC0 + p));
    bp_mode = 1'b1;
    issue(32'h4000, 4);
    wait_done_n(1);
    @(negedge clk);
    bp_mode = 1'b0;
    mem_ready = 1'b1;
    chk(beat_n == 4, "R7 beat count under stall", 64'(beat_n), 4);
    for (int k = 0; k < 4; k++)
      chk(b_data[k] == 32'(32'hC0 + k) && b_be[k] == 4'hF, "R7 order under stall",
          64'(b_data[k]), 64'(32'hC0 + k));
  endtask

  task automatic t_collision();
    fresh();
    put_word(0, 0, 32'hD0); put_word(3, 1, 32'hD3); put_word(1, 1, 32'hD1);
    issue(32'h5000, 2);
    wait_done_n(1);
    @(negedge clk);
    chk(b_data[1] == 32'hD1, "R9 lower port wins", 64'(b_data[1]), 64'hD1);
    chk(wv[3] && !wv[1], "R9 loser stalled", 64'(wv), 64'h8);
    wv[3] = 1'b0;
  endtask

  task automatic t_queue_and_reuse();
    fresh();
    put_word(2, 0, 32'hE0);
    issue(32'h6000, 1);
    cmd_base = 32'h7000;
    cmd_size = ZW'(1);
    cmd_valid = 1'b1;
    chk(!cmd_ready, "R10 ready low while busy", 64'(cmd_ready), 0);
    while (wv[2]) @(negedge clk);
    ws[2*SW +: SW] = '0;
    wd[2*32 +: 32] = 32'hE1;
    wv[2] = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done_n(2);
    @(negedge clk);
    chk(beat_n == 2 && b_data[0] == 32'hE0 && b_addr[0] == 32'h6000,
        "R10 first burst", 64'(b_addr[0]), 64'h6000);
    chk(b_data[1] == 32'hE1 && b_addr[1] == 32'h7000 && b_last[1],
        "R10 reused slot new base", 64'(b_addr[1]), 64'h7000);
  endtask

  task automatic t_size_zero();
    fresh();
    @(negedge clk);
    cmd_base = 32'h8000;
    cmd_size = '0;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!busy, "R2 size zero ignored", 64'(busy), 0);
    repeat (4) @(negedge clk);
    chk(beat_n == 0 && done_n == 0 && cmd_ready, "R2 no beats for size zero",
        64'(beat_n), 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_burst();
        t_gap_and_range();
        t_backpressure();
        t_collision();
        t_queue_and_reuse();
        t_size_zero();
      end
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule